// File: doc/BRIEF.md
# Trap Return State Restorer

This block carries out the state restore for the two trap-return commands of a processor core, "done" and "retry". When a command arrives it takes the top entry of the trap stack: the saved program counter, the saved next program counter, the packed saved-state word and, when hypervisor support is built in, the saved hypervisor state for the current level. From these it produces the program counter pair to resume at and the restored condition codes, address-space identifier, processor state, current window pointer and global level. It also lowers the trap level by one.

A "done" command resumes after the trapped instruction, and a "retry" command re-executes it. When the restored global level differs from the one in use, the block raises a one-cycle request so that a separate datapath swaps the global register bank. A command issued at trap level zero is refused. The block then flags an illegal instruction and keeps every restored output as it was. The trap stack storage, interrupt evaluation and the bank copy itself live outside this block.

Top module: `trap_return_restorer`

## Requirements
- R1: During and right after reset every output is zero, including `ret_done`, `ret_illegal` and `bank_swap_req`.
- R2: A done command (`cmd_retry`=0) sets `pc_out` to `sv_tnpc` and `npc_out` to `sv_tnpc`+4, wrapping modulo 2^PC_W.
- R3: A retry command (`cmd_retry`=1) sets `pc_out` to `sv_tpc` and `npc_out` to `sv_tnpc`.
- R4: The condition-code byte sits in saved-state bits 39:32. `xcc_out` takes bits 39:36 and `icc_out` takes bits 35:32. `asi_out` takes bits 31:24.
- R5: `pstate_out` equals saved-state bits 19:8 ANDed with 12'hF3F, so bits 7:6 of the result are always zero.
- R6: `cwp_out` equals NWIN-1 minus (saved-state bits 7:0 modulo NWIN).
- R7: An accepted command sets `tl_out` to `trap_level`-1.
- R8: With HV_EN=1, `gl_out` takes saved-state bits 42:40 and `hpstate_out` takes `sv_hpstate`. `bank_swap_req` is high in the `ret_done` cycle exactly when bits 42:40 differ from `cur_gl`.
- R9: With HV_EN=0, `gl_out` and `hpstate_out` keep their values and `bank_swap_req` never rises.
- R10: A command at `trap_level`=0 gives a one-cycle `ret_illegal` with `ret_done` low, and it leaves every restored output unchanged.
- R11: All restored outputs change together at the clock edge that samples `cmd_valid`. `ret_done` is high for exactly the following cycle. Without `cmd_valid` the outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | One-cycle trap-return command |
| cmd_retry | input | 1 | 1 = retry, 0 = done |
| trap_level | input | TL_W | Current trap level |
| cur_gl | input | 3 | Global level in use |
| sv_tpc | input | PC_W | Saved trapped PC |
| sv_tnpc | input | PC_W | Saved trapped next PC |
| sv_tstate | input | TSTATE_W | Packed saved-state word |
| sv_hpstate | input | HPS_W | Saved hypervisor state for this level |
| pc_out | output | PC_W | Resume PC |
| npc_out | output | PC_W | Resume next PC |
| xcc_out | output | 4 | 64-bit condition codes |
| icc_out | output | 4 | 32-bit condition codes |
| asi_out | output | 8 | Address-space identifier |
| pstate_out | output | 12 | Processor state |
| cwp_out | output | CWP_W | Internal window pointer |
| gl_out | output | 3 | Global level |
| hpstate_out | output | HPS_W | Hypervisor state |
| tl_out | output | TL_W | New trap level |
| bank_swap_req | output | 1 | Global bank swap needed |
| ret_illegal | output | 1 | Command refused at level zero |
| ret_done | output | 1 | Restore completed strobe |

## Verification
All 256 values of the low saved-state byte are swept. The same counter also feeds the condition codes, the address-space byte, the processor-state field and the global levels, so every window pointer value passes through the modulo-and-invert step. This is done once with a six-window build, where the modulo is not a plain bit slice, and once with an eight-window build. Done and retry alternate, which separates the two program counter sequences, and saved next-PC values near the top of the range show that the +4 wraps. Pairs of saved and current global levels that are equal and unequal separate the swap request from a plain level copy. Level-zero commands and idle cycles with changed inputs show that nothing moves when it must not.

// File: rtl/trs_pkg.sv
// Package: shared types and field positions for the trap return restorer.
// Assumes the saved-state word is at least 43 bits wide.
package trs_pkg;

    typedef enum logic {
        RET_KIND_DONE  = 1'b0,
        RET_KIND_RETRY = 1'b1
    } ret_kind_e;

    localparam int CCR_LSB    = 32;
    localparam int ASI_LSB    = 24;
    localparam int PST_LSB    = 8;
    localparam int CWP_LSB    = 0;
    localparam int GL_LSB     = 40;
    localparam logic [11:0] PST_KEEP = 12'hF3F;

    typedef struct packed {
        logic [3:0]  xcc;
        logic [3:0]  icc;
        logic [7:0]  asi;
        logic [11:0] pstate;
        logic [2:0]  gl;
    } ret_fields_t;

endpackage

// File: rtl/trs_field_unpack.sv
// Module: splits the packed saved-state word into its restored fields and
// converts the saved window pointer into the internal window numbering.
// Assumes TSTATE_W >= 43 and NWIN <= 256.
module trs_field_unpack
    import trs_pkg::*;
#(
    parameter int TSTATE_W = 64,
    parameter int NWIN     = 8,
    parameter int CWP_W    = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic [TSTATE_W-1:0] tstate,
    output ret_fields_t         fields,
    output logic [CWP_W-1:0]    cwp
);

    localparam logic [7:0] TOP_WIN = 8'(NWIN - 1);
    localparam bit         POW2    = (NWIN & (NWIN - 1)) == 0;

    logic [7:0] raw_cwp;
    logic [7:0] red_cwp;
    logic [7:0] inv_cwp;
    logic       unused_bits;

    assign raw_cwp = tstate[CWP_LSB +: 8];

    // Reduce the saved pointer into the window range.
    generate
        if (POW2) begin : g_mask
            assign red_cwp = raw_cwp & TOP_WIN;
        end else begin : g_mod
            assign red_cwp = raw_cwp % 8'(NWIN);
        end
    endgenerate

    // Field extraction and window pointer inversion.
    always_comb begin
        fields.xcc    = tstate[CCR_LSB + 4 +: 4];
        fields.icc    = tstate[CCR_LSB +: 4];
        fields.asi    = tstate[ASI_LSB +: 8];
        fields.pstate = tstate[PST_LSB +: 12] & PST_KEEP;
        fields.gl     = tstate[GL_LSB +: 3];
        inv_cwp       = TOP_WIN - red_cwp;
        cwp           = inv_cwp[CWP_W-1:0];
    end

    assign unused_bits = ^{tstate[TSTATE_W-1:43], tstate[23:20], inv_cwp};

endmodule

// File: rtl/trs_pc_seq.sv
// Module: picks the resume PC pair for a done or retry command.
// Assumes instructions are four bytes and the PC wraps at 2^PC_W.
module trs_pc_seq
    import trs_pkg::*;
#(
    parameter int PC_W = 64
) (
    input  ret_kind_e         kind,
    input  logic [PC_W-1:0]   tpc,
    input  logic [PC_W-1:0]   tnpc,
    output logic [PC_W-1:0]   pc,
    output logic [PC_W-1:0]   npc
);

    localparam logic [PC_W-1:0] INSN_BYTES = PC_W'(4);

    // Retry re-executes the trapped instruction; done skips it.
    always_comb begin
        if (kind == RET_KIND_RETRY) begin
            pc  = tpc;
            npc = tnpc;
        end else begin
            pc  = tnpc;
            npc = tnpc + INSN_BYTES;
        end
    end

endmodule

// File: rtl/trs_level_ctrl.sv
// Module: computes the new trap level, global level, hypervisor state and
// the bank-swap request. Assumes the caller has rejected trap level zero.
module trs_level_ctrl #(
    parameter bit HV_EN = 1'b1,
    parameter int TL_W  = 3,
    parameter int HPS_W = 12
) (
    input  logic [TL_W-1:0]  tl,
    input  logic [2:0]       cur_gl,
    input  logic [2:0]       saved_gl,
    input  logic [HPS_W-1:0] saved_hps,
    input  logic [2:0]       held_gl,
    input  logic [HPS_W-1:0] held_hps,
    output logic [TL_W-1:0]  tl_nxt,
    output logic [2:0]       gl_nxt,
    output logic [HPS_W-1:0] hps_nxt,
    output logic             swap
);

    // Trap level always drops by one on an accepted command.
    assign tl_nxt = tl - TL_W'(1);

    generate
        if (HV_EN) begin : g_hv
            // Restore level and state; swap banks only on a level change.
            always_comb begin
                gl_nxt  = saved_gl;
                hps_nxt = saved_hps;
                swap    = saved_gl != cur_gl;
            end
            logic unused_held;
            assign unused_held = ^{held_gl, held_hps};
        end else begin : g_nohv
            // Without hypervisor support the level and state are kept.
            always_comb begin
                gl_nxt  = held_gl;
                hps_nxt = held_hps;
                swap    = 1'b0;
            end
            logic unused_saved;
            assign unused_saved = ^{cur_gl, saved_gl, saved_hps};
        end
    endgenerate

endmodule

// File: rtl/trap_return_restorer.sv
// Module: top of the trap return state restorer. It registers every restored
// field in the cycle the command is sampled and strobes done (or illegal)
// for the following cycle. Assumes cmd inputs are stable around the edge.
module trap_return_restorer
    import trs_pkg::*;
#(
    parameter int PC_W     = 64,
    parameter int TSTATE_W = 64,
    parameter int NWIN     = 8,
    parameter int TL_W     = 3,
    parameter int HPS_W    = 12,
    parameter bit HV_EN    = 1'b1,
    parameter int CWP_W    = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic                cmd_retry,
    input  logic [TL_W-1:0]     trap_level,
    input  logic [2:0]          cur_gl,
    input  logic [PC_W-1:0]     sv_tpc,
    input  logic [PC_W-1:0]     sv_tnpc,
    input  logic [TSTATE_W-1:0] sv_tstate,
    input  logic [HPS_W-1:0]    sv_hpstate,
    output logic [PC_W-1:0]     pc_out,
    output logic [PC_W-1:0]     npc_out,
    output logic [3:0]          xcc_out,
    output logic [3:0]          icc_out,
    output logic [7:0]          asi_out,
    output logic [11:0]         pstate_out,
    output logic [CWP_W-1:0]    cwp_out,
    output logic [2:0]          gl_out,
    output logic [HPS_W-1:0]    hpstate_out,
    output logic [TL_W-1:0]     tl_out,
    output logic                bank_swap_req,
    output logic                ret_illegal,
    output logic                ret_done
);

    ret_kind_e         kind;
    ret_fields_t       fields;
    logic [CWP_W-1:0]  cwp_nxt;
    logic [PC_W-1:0]   pc_nxt;
    logic [PC_W-1:0]   npc_nxt;
    logic [TL_W-1:0]   tl_nxt;
    logic [2:0]        gl_nxt;
    logic [HPS_W-1:0]  hps_nxt;
    logic              swap_nxt;
    logic              at_level0;

    assign kind      = cmd_retry ? RET_KIND_RETRY : RET_KIND_DONE;
    assign at_level0 = trap_level == '0;

    trs_field_unpack #(
        .TSTATE_W(TSTATE_W), .NWIN(NWIN), .CWP_W(CWP_W)
    ) u_unpack (
        .tstate(sv_tstate), .fields(fields), .cwp(cwp_nxt)
    );

    trs_pc_seq #(.PC_W(PC_W)) u_pcseq (
        .kind(kind), .tpc(sv_tpc), .tnpc(sv_tnpc),
        .pc(pc_nxt), .npc(npc_nxt)
    );

    trs_level_ctrl #(
        .HV_EN(HV_EN), .TL_W(TL_W), .HPS_W(HPS_W)
    ) u_level (
        .tl(trap_level), .cur_gl(cur_gl), .saved_gl(fields.gl),
        .saved_hps(sv_hpstate), .held_gl(gl_out), .held_hps(hpstate_out),
        .tl_nxt(tl_nxt), .gl_nxt(gl_nxt), .hps_nxt(hps_nxt), .swap(swap_nxt)
    );

    // Restored state: loaded as one group on an accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_out      <= '0;
            npc_out     <= '0;
            xcc_out     <= '0;
            icc_out     <= '0;
            asi_out     <= '0;
            pstate_out  <= '0;
            cwp_out     <= '0;
            gl_out      <= '0;
            hpstate_out <= '0;
            tl_out      <= '0;
        end else if (cmd_valid && !at_level0) begin
            pc_out      <= pc_nxt;
            npc_out     <= npc_nxt;
            xcc_out     <= fields.xcc;
            icc_out     <= fields.icc;
            asi_out     <= fields.asi;
            pstate_out  <= fields.pstate;
            cwp_out     <= cwp_nxt;
            gl_out      <= gl_nxt;
            hpstate_out <= hps_nxt;
            tl_out      <= tl_nxt;
        end
    end

    // Completion strobes: high for one cycle after the command edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_done      <= 1'b0;
            ret_illegal   <= 1'b0;
            bank_swap_req <= 1'b0;
        end else begin
            ret_done      <= cmd_valid && !at_level0;
            ret_illegal   <= cmd_valid && at_level0;
            bank_swap_req <= cmd_valid && !at_level0 && swap_nxt;
        end
    end

endmodule

// File: rtl/trap_return_restorer_checker.sv
// Checker: temporal properties of the trap return restorer, bound to the top.
module trap_return_restorer_checker #(
    parameter int PC_W  = 64,
    parameter int NWIN  = 8,
    parameter int TL_W  = 3,
    parameter int CWP_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             cmd_retry,
    input logic [TL_W-1:0]  trap_level,
    input logic [PC_W-1:0]  pc_out,
    input logic [PC_W-1:0]  npc_out,
    input logic [CWP_W-1:0] cwp_out,
    input logic [TL_W-1:0]  tl_out,
    input logic             bank_swap_req,
    input logic             ret_illegal,
    input logic             ret_done
);

    assert_done_after_cmd_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && trap_level != '0 |=> ret_done);

    assert_idle_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !ret_done && $stable(tl_out) && $stable(pc_out));

    assert_level0_refused_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && trap_level == '0 |=> ret_illegal && !ret_done
            && $stable(pc_out) && $stable(cwp_out) && $stable(tl_out));

    assert_illegal_excl_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ret_illegal && ret_done));

    assert_swap_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bank_swap_req |-> ret_done);

    assert_done_npc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && trap_level != '0 && !cmd_retry |=> npc_out == pc_out + PC_W'(4));

    assert_cwp_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ret_done |-> cwp_out <= CWP_W'(NWIN - 1));

    assert_tl_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && trap_level != '0 |=> tl_out == $past(trap_level) - TL_W'(1));

endmodule

bind trap_return_restorer trap_return_restorer_checker #(
    .PC_W(PC_W), .NWIN(NWIN), .TL_W(TL_W), .CWP_W(CWP_W)
) u_checker (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_retry(cmd_retry),
    .trap_level(trap_level), .pc_out(pc_out), .npc_out(npc_out),
    .cwp_out(cwp_out), .tl_out(tl_out), .bank_swap_req(bank_swap_req),
    .ret_illegal(ret_illegal), .ret_done(ret_done)
);

// File: tb/trap_return_restorer_bench.sv
// Bench: sweeps the saved-state byte through all values on a six-window
// build with hypervisor support and an eight-window build without it.
module trap_return_restorer_bench;

    localparam int PC_W = 64;
    localparam int TS_W = 64;
    localparam int TL_W = 3;
    localparam int HPS_W = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic cmd_retry = 1'b0;
    logic [TL_W-1:0] trap_level = '0;
    logic [2:0] cur_gl = '0;
    logic [PC_W-1:0] sv_tpc = '0;
    logic [PC_W-1:0] sv_tnpc = '0;
    logic [TS_W-1:0] sv_tstate = '0;
    logic [HPS_W-1:0] sv_hpstate = '0;

    logic [PC_W-1:0] pc_a, npc_a, pc_b, npc_b;
    logic [3:0] xcc_a, icc_a, xcc_b, icc_b;
    logic [7:0] asi_a, asi_b;
    logic [11:0] pst_a, pst_b;
    logic [2:0] cwp_a, cwp_b, gl_a, gl_b;
    logic [HPS_W-1:0] hps_a, hps_b;
    logic [TL_W-1:0] tl_a, tl_b;
    logic sw_a, sw_b, ill_a, ill_b, dn_a, dn_b;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    trap_return_restorer #(.NWIN(6), .HV_EN(1'b1)) u_trap_return_restorer (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_retry(cmd_retry),
        .trap_level(trap_level), .cur_gl(cur_gl), .sv_tpc(sv_tpc),
        .sv_tnpc(sv_tnpc), .sv_tstate(sv_tstate), .sv_hpstate(sv_hpstate),
        .pc_out(pc_a), .npc_out(npc_a), .xcc_out(xcc_a), .icc_out(icc_a),
        .asi_out(asi_a), .pstate_out(pst_a), .cwp_out(cwp_a), .gl_out(gl_a),
        .hpstate_out(hps_a), .tl_out(tl_a), .bank_swap_req(sw_a),
        .ret_illegal(ill_a), .ret_done(dn_a)
    );

    trap_return_restorer #(.NWIN(8), .HV_EN(1'b0)) u_nohv (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_retry(cmd_retry),
        .trap_level(trap_level), .cur_gl(cur_gl), .sv_tpc(sv_tpc),
        .sv_tnpc(sv_tnpc), .sv_tstate(sv_tstate), .sv_hpstate(sv_hpstate),
        .pc_out(pc_b), .npc_out(npc_b), .xcc_out(xcc_b), .icc_out(icc_b),
        .asi_out(asi_b), .pstate_out(pst_b), .cwp_out(cwp_b), .gl_out(gl_b),
        .hpstate_out(hps_b), .tl_out(tl_b), .bank_swap_req(sw_b),
        .ret_illegal(ill_b), .ret_done(dn_b)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Present the inputs for sweep value c, without issuing a command.
    task automatic load(input int c, input int tl);
        logic [7:0] b;
        b = 8'(c);
        cmd_retry  = b[0];
        trap_level = TL_W'(tl);
        cur_gl     = b[5:3];
        sv_tpc     = {32'h1234_0000, 24'h0, b};
        sv_tnpc    = {56'hFFFF_FFFF_FFFF_FF, b};
        sv_hpstate = {4'hA, b};
        sv_tstate  = '0;
        sv_tstate[7:0]   = b;
        sv_tstate[19:8]  = {b[3:0], b};
        sv_tstate[31:24] = b ^ 8'h5A;
        sv_tstate[39:32] = b;
        sv_tstate[42:40] = b[2:0];
    endtask

    // One-cycle command pulse; returns at the negedge after the edge.
    task automatic pulse;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] keep_pc;
        logic [2:0]  keep_cwp;
        logic [TL_W-1:0] keep_tl;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 pc", pc_a, 0);
        check("R1 cwp", 64'(cwp_a), 0);
        check("R1 strobes", {61'h0, dn_a, ill_a, sw_a}, 0);
        check("R1 tl", 64'(tl_a), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {61'h0, dn_a, ill_a, sw_a}, 0);

        for (int c = 0; c < 256; c++) begin
            logic [7:0] b;
            int tl;
            b  = 8'(c);
            tl = (c % 7) + 1;
            load(c, tl);
            pulse();
            check("R11 done", 64'(dn_a), 1);
            check("R10 no illegal", 64'(ill_a), 0);
            if (b[0]) begin
                check("R3 pc", pc_a, {32'h1234_0000, 24'h0, b});
                check("R3 npc", npc_a, {56'hFFFF_FFFF_FFFF_FF, b});
            end else begin
                check("R2 pc", pc_a, {56'hFFFF_FFFF_FFFF_FF, b});
                check("R2 npc", npc_a, {56'hFFFF_FFFF_FFFF_FF, b} + 64'd4);
            end
            check("R4 xcc", 64'(xcc_a), 64'(b[7:4]));
            check("R4 icc", 64'(icc_a), 64'(b[3:0]));
            check("R4 asi", 64'(asi_a), 64'(b ^ 8'h5A));
            check("R5 pstate", 64'(pst_a), 64'({b[3:0], b} & 12'hF3F));
            check("R6 cwp n6", 64'(cwp_a), 64'(5 - (c % 6)));
            check("R6 cwp n8", 64'(cwp_b), 64'(7 - (c % 8)));
            check("R7 tl", 64'(tl_a), 64'(tl - 1));
            check("R8 gl", 64'(gl_a), 64'(b[2:0]));
            check("R8 hpstate", 64'(hps_a), 64'({4'hA, b}));
            check("R8 swap", 64'(sw_a), 64'(b[2:0] != b[5:3]));
            check("R9 gl", 64'(gl_b), 0);
            check("R9 hpstate", 64'(hps_b), 0);
            check("R9 swap", 64'(sw_b), 0);
            @(negedge clk);
            check("R11 done one cycle", {62'h0, dn_a, sw_a}, 0);
        end

        // R11: changed inputs without a command leave outputs alone
        keep_pc  = pc_a;
        keep_cwp = cwp_a;
        keep_tl  = tl_a;
        load(17, 5);
        repeat (3) @(negedge clk);
        check("R11 idle pc", pc_a, keep_pc);
        check("R11 idle cwp", 64'(cwp_a), 64'(keep_cwp));
        check("R11 idle tl", 64'(tl_a), 64'(keep_tl));

        // R10: command at level zero is refused
        for (int c = 40; c < 48; c++) begin
            load(c, 0);
            pulse();
            check("R10 illegal", 64'(ill_a), 1);
            check("R10 done low", 64'(dn_a), 0);
            check("R10 pc kept", pc_a, keep_pc);
            check("R10 cwp kept", 64'(cwp_a), 64'(keep_cwp));
            check("R10 tl kept", 64'(tl_a), 64'(keep_tl));
            check("R10 swap low", 64'(sw_a), 0);
            @(negedge clk);
            check("R10 illegal one cycle", 64'(ill_a), 0);
        end

        // R8: equal levels request no swap
        load(9, 4);
        cur_gl = 3'd1;
        pulse();
        check("R8 equal level no swap", 64'(sw_a), 0);
        check("R8 gl", 64'(gl_a), 1);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule